// File: doc/BRIEF.md
# Acquisition Sample Ring Buffer

This block sits between a conversion engine and a host. Every sample that the converter presents on a valid/data strobe is written into a circular buffer of word-wide slots. The host drains the buffer through a simple addressed word port. It reads the slots directly, and it reports its progress by writing a read pointer. The buffer depth need not be a power of two. Both pointers wrap explicitly from the last slot back to slot zero.

The block owns the write pointer and the host owns the read pointer, and both can be read back. From the two pointers the block derives the number of samples waiting. When a stored sample brings that number up to a programmable threshold, the block raises a fill flag. A sample that arrives while the buffer is full is dropped and flagged. A converter-side error strobe sets a third flag. The flags sit in a write-one-to-clear register. A mask register with the same bit layout gates them onto a single registered interrupt line.

Top module: `ring_sample_buffer`

## Requirements
- R1: After reset the write pointer, read pointer, count, flags, mask and interrupt are all zero, and the threshold equals DEPTH/2 rounded down.
- R2: An accepted sample is stored in the slot named by the write pointer, and that pointer then advances by one, going from DEPTH-1 back to 0.
- R3: The count register reads write pointer minus read pointer, plus DEPTH when that difference is negative, and never reaches DEPTH.
- R4: A host write to the read-pointer register (offset 1) takes effect only when the value is below DEPTH; a larger value leaves the pointer unchanged.
- R5: A sample that arrives when the count is DEPTH-1 is not stored, leaves the write pointer unchanged, and sets flag bit 1 (value 0x02).
- R6: A stored sample whose post-store count is at least the threshold (offset 2, read/write) sets flag bit 0 (value 0x01).
- R7: A pulse on conv_err sets flag bit 2 (value 0x04).
- R8: Writing the flag register (offset 3) clears each flag whose data bit is one; a flag being set in the same cycle stays set.
- R9: irq is the OR over the flag bits ANDed with the mask register (offset 4). It follows the registers one cycle later, and a zero mask holds it low.
- R10: host_rdata carries the read result on the cycle after host_rd. Addresses below DEPTH return the slot contents, REG_BASE+0 returns the write pointer, REG_BASE+5 returns the count, and unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe from the converter |
| smp_data | input | DW | Sample word |
| conv_err | input | 1 | Converter hardware-error strobe |
| host_addr | input | HAW | Host word address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data, valid the cycle after host_rd |
| irq | output | 1 | Masked interrupt request |

## Verification
Pointer, count, threshold and flag changes take effect on the clock edge that samples the strobe. Read data for any address appears one edge after host_rd, and irq follows a flag or mask change one edge later still. The bench drives every input on the falling edge. It issues each read as a single-cycle strobe and samples host_rdata on the next falling edge. For irq it waits one extra cycle after the write or strobe that should move it. This fixes each observation between the edge that produces the result and the edge that could change it.

// File: rtl/ring_buf_pkg.sv
package ring_buf_pkg;
  localparam int FLG_IN_FULL  = 0;
  localparam int FLG_IN_SWERR = 1;
  localparam int FLG_IN_HWERR = 2;

  typedef enum logic [2:0] {
    RG_FRONT  = 3'd0,
    RG_REAR   = 3'd1,
    RG_THRESH = 3'd2,
    RG_FLAGS  = 3'd3,
    RG_MASK   = 3'd4,
    RG_COUNT  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/ring_ptrs.sv
module ring_ptrs #(
  parameter int DEPTH = 2003,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          rear_we,
  input  logic          rear_ok,
  input  logic [AW-1:0] rear_wdata,
  output logic [AW-1:0] front,
  output logic [AW-1:0] rear,
  output logic [AW-1:0] count,
  output logic          accept,
  output logic          drop
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW-1:0] DEP  = AW'(DEPTH);

  logic [AW-1:0] front_nxt;
  logic          is_full;

  // explicit modulo step: the depth is not a power of two
  assign front_nxt = (front == LAST) ? '0 : front + AW'(1);
  assign is_full   = (front_nxt == rear);
  assign accept    = push_req && !is_full;
  assign drop      = push_req && is_full;

  always_comb begin
    if (front >= rear) count = front - rear;
    else               count = front + DEP - rear;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      front <= '0;
      rear  <= '0;
    end else begin
      if (accept) front <= front_nxt;
      if (rear_we && rear_ok) rear <= rear_wdata;
    end
  end
endmodule

// File: rtl/ring_store.sv
module ring_store #(
  parameter int DEPTH = 2003,
  parameter int AW    = 11,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ring_flags.sv
module ring_flags #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] set_vec,
  input  logic          clr_we,
  input  logic [FW-1:0] clr_vec,
  input  logic          mask_we,
  input  logic [FW-1:0] mask_wdata,
  output logic [FW-1:0] flags,
  output logic [FW-1:0] mask,
  output logic          irq
);
  logic [FW-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_vec : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      mask  <= '0;
      irq   <= 1'b0;
    end else begin
      // a new event outranks a clear in the same cycle
      flags <= (flags & ~clr_eff) | set_vec;
      if (mask_we) mask <= mask_wdata;
      irq <= |(flags & mask);
    end
  end
endmodule

// File: rtl/ring_sample_buffer.sv
module ring_sample_buffer
  import ring_buf_pkg::*;
#(
  parameter int DEPTH = 2003,
  parameter int DW    = 16,
  parameter int HAW   = 12,
  parameter int FW    = 8,
  parameter logic [HAW-1:0] REG_BASE = 12'hFF0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           smp_valid,
  input  logic [DW-1:0]  smp_data,
  input  logic           conv_err,
  input  logic [HAW-1:0] host_addr,
  input  logic           host_wr,
  input  logic           host_rd,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic           irq
);
  localparam int AW = $clog2(DEPTH + 1);

  logic [AW-1:0] front_q, rear_q, fill_cnt, thr_q;
  logic          accept, drop;
  logic [FW-1:0] flag_q, mask_q, set_vec;
  logic [AW:0]   cnt_inc;
  logic          hit_reg, hit_mem;
  reg_sel_e      sel;
  logic          wr_rear, wr_thr, wr_flags, wr_mask;
  logic [DW-1:0] mem_q, reg_q;
  logic          src_mem_q;

  // host address decode
  assign hit_reg  = (host_addr[HAW-1:3] == REG_BASE[HAW-1:3]);
  assign hit_mem  = (host_addr < HAW'(DEPTH));
  assign sel      = reg_sel_e'(host_addr[2:0]);
  assign wr_rear  = host_wr && hit_reg && (sel == RG_REAR);
  assign wr_thr   = host_wr && hit_reg && (sel == RG_THRESH);
  assign wr_flags = host_wr && hit_reg && (sel == RG_FLAGS);
  assign wr_mask  = host_wr && hit_reg && (sel == RG_MASK);

  ring_ptrs #(.DEPTH(DEPTH), .AW(AW)) u_ptrs (
    .clk       (clk),
    .rst       (rst),
    .push_req  (smp_valid),
    .rear_we   (wr_rear),
    .rear_ok   (host_wdata < DW'(DEPTH)),
    .rear_wdata(host_wdata[AW-1:0]),
    .front     (front_q),
    .rear      (rear_q),
    .count     (fill_cnt),
    .accept    (accept),
    .drop      (drop)
  );

  ring_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk  (clk),
    .we   (accept),
    .waddr(front_q),
    .wdata(smp_data),
    .re   (host_rd),
    .raddr(hit_mem ? host_addr[AW-1:0] : '0),
    .rdata(mem_q)
  );

  assign cnt_inc = {1'b0, fill_cnt} + (AW+1)'(1);

  always_comb begin
    set_vec               = '0;
    set_vec[FLG_IN_FULL]  = accept && (cnt_inc >= {1'b0, thr_q});
    set_vec[FLG_IN_SWERR] = drop;
    set_vec[FLG_IN_HWERR] = conv_err;
  end

  ring_flags #(.FW(FW)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .set_vec   (set_vec),
    .clr_we    (wr_flags),
    .clr_vec   (host_wdata[FW-1:0]),
    .mask_we   (wr_mask),
    .mask_wdata(host_wdata[FW-1:0]),
    .flags     (flag_q),
    .mask      (mask_q),
    .irq       (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) thr_q <= AW'(DEPTH / 2);
    else if (wr_thr) thr_q <= host_wdata[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      src_mem_q <= 1'b0;
    end else if (host_rd) begin
      src_mem_q <= hit_mem;
      reg_q     <= '0;
      if (hit_reg) begin
        case (sel)
          RG_FRONT:  reg_q <= DW'(front_q);
          RG_REAR:   reg_q <= DW'(rear_q);
          RG_THRESH: reg_q <= DW'(thr_q);
          RG_FLAGS:  reg_q <= DW'(flag_q);
          RG_MASK:   reg_q <= DW'(mask_q);
          RG_COUNT:  reg_q <= DW'(fill_cnt);
          default:   reg_q <= '0;
        endcase
      end
    end
  end

  assign host_rdata = src_mem_q ? mem_q : reg_q;
endmodule

// File: rtl/ring_sample_buffer_chk.sv
module ring_sample_buffer_chk #(
  parameter int DEPTH = 2003,
  parameter int AW    = 11,
  parameter int DW    = 16,
  parameter int HAW   = 12,
  parameter int FW    = 8,
  parameter logic [HAW-1:0] REG_BASE = 12'hFF0
) (
  input logic           clk,
  input logic           rst,
  input logic           smp_valid,
  input logic           conv_err,
  input logic           host_wr,
  input logic [HAW-1:0] host_addr,
  input logic [DW-1:0]  host_wdata,
  input logic [AW-1:0]  front,
  input logic [AW-1:0]  rear,
  input logic [AW-1:0]  count,
  input logic [FW-1:0]  flags,
  input logic [FW-1:0]  mask,
  input logic           irq
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [HAW-1:0] A_REAR  = REG_BASE + HAW'(1);
  localparam logic [HAW-1:0] A_FLAGS = REG_BASE + HAW'(3);

  // R3: occupancy stays below the depth
  p_count_range_r3: assert property (@(posedge clk) disable iff (rst)
    count <= LAST);

  // R2: accepted sample steps the write pointer modulo DEPTH
  p_front_step_r2: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && count != LAST) |=>
      front == (($past(front) == LAST) ? '0 : $past(front) + AW'(1)));

  // R5: sample into a full buffer is dropped and flagged
  p_drop_full_r5: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && count == LAST) |=> ($stable(front) && flags[1]));

  // R7: converter error strobe lands in its flag
  p_hwerr_r7: assert property (@(posedge clk) disable iff (rst)
    conv_err |=> flags[2]);

  // R9: a zero mask keeps the interrupt low
  p_mask_off_r9: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq);

  // R4: out-of-range read-pointer write is ignored
  p_rear_guard_r4: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == A_REAR && host_wdata >= DW'(DEPTH)) |=> $stable(rear));

  // R8: write-one clears the fill flag when no sample arrives
  p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == A_FLAGS && host_wdata[0] && !smp_valid) |=> !flags[0]);
endmodule

bind ring_sample_buffer ring_sample_buffer_chk #(
  .DEPTH(DEPTH), .AW(AW), .DW(DW), .HAW(HAW), .FW(FW), .REG_BASE(REG_BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_valid (smp_valid),
  .conv_err  (conv_err),
  .host_wr   (host_wr),
  .host_addr (host_addr),
  .host_wdata(host_wdata),
  .front     (front_q),
  .rear      (rear_q),
  .count     (fill_cnt),
  .flags     (flag_q),
  .mask      (mask_q),
  .irq       (irq)
);

// File: tb/ring_sample_buffer_tb.sv
module ring_sample_buffer_tb;
  localparam int DEPTH = 13;
  localparam logic [11:0] RB = 12'hFF0;
  localparam logic [11:0] A_FRONT = RB + 12'd0, A_REAR = RB + 12'd1,
    A_THR = RB + 12'd2, A_FLAGS = RB + 12'd3, A_MASK = RB + 12'd4, A_CNT = RB + 12'd5;

  logic clk = 1'b0, rst = 1'b1;
  logic smp_valid = 0, conv_err = 0, host_wr = 0, host_rd = 0;
  logic [15:0] smp_data = '0, host_wdata = '0, host_rdata;
  logic [11:0] host_addr = '0;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ring_sample_buffer #(.DEPTH(DEPTH), .DW(16), .HAW(12), .FW(8), .REG_BASE(RB)) u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data), .conv_err(conv_err),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq)
  );

  // op: 0 push sample, 1 host write, 2 host read and compare
  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [15:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{2'd0, 12'h000, 16'h1111, 4'd2},
    '{2'd0, 12'h000, 16'h2222, 4'd2},
    '{2'd0, 12'h000, 16'h3333, 4'd2},
    '{2'd2, 12'h000, 16'h1111, 4'd10},
    '{2'd2, 12'h002, 16'h3333, 4'd10},
    '{2'd2, A_FRONT, 16'd3,    4'd2},
    '{2'd2, A_CNT,   16'd3,    4'd3},
    '{2'd1, A_REAR,  16'd2,    4'd4},
    '{2'd2, A_CNT,   16'd1,    4'd3},
    '{2'd1, A_REAR,  16'd20,   4'd4},
    '{2'd2, A_REAR,  16'd2,    4'd4},
    '{2'd2, A_FLAGS, 16'h0000, 4'd8}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] d);
    @(negedge clk); smp_valid = 1; smp_data = d;
    @(negedge clk); smp_valid = 0;
  endtask

  task automatic hwrite(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hread(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk); host_rd = 1; host_addr = a;
    @(negedge clk); host_rd = 0; d = host_rdata;
  endtask

  task automatic expect_reg(input string tag, input logic [11:0] a, input logic [15:0] exp);
    logic [15:0] v;
    hread(a, v);
    check(tag, v, exp);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset values
    check("R1 irq", {15'd0, irq}, 16'd0);
    expect_reg("R1 front", A_FRONT, 16'd0);
    expect_reg("R1 rear", A_REAR, 16'd0);
    expect_reg("R1 count", A_CNT, 16'd0);
    expect_reg("R1 flags", A_FLAGS, 16'd0);
    expect_reg("R1 mask", A_MASK, 16'd0);
    expect_reg("R1 threshold", A_THR, 16'd6);

    for (int i = 0; i < 12; i++) begin
      case (VECS[i].op)
        2'd0: push(VECS[i].data);
        2'd1: hwrite(VECS[i].addr, VECS[i].data);
        default: begin
          hread(VECS[i].addr, v);
          check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].data);
        end
      endcase
    end

    // R2 R6: fill to DEPTH-1 across the wrap, crossing the threshold
    for (int i = 0; i < 11; i++) push(16'hA000 + 16'(i));
    expect_reg("R2 front wrapped", A_FRONT, 16'd1);
    expect_reg("R3 count negative diff", A_CNT, 16'd12);
    expect_reg("R2 slot 0 after wrap", 12'h000, 16'hA00A);
    expect_reg("R6 fill flag", A_FLAGS, 16'h0001);

    // R5: overflow drops the sample
    push(16'hBEEF);
    expect_reg("R5 front held", A_FRONT, 16'd1);
    expect_reg("R5 swerr flag", A_FLAGS, 16'h0003);
    expect_reg("R5 slot untouched", 12'h001, 16'h2222);

    // R8: write-one-to-clear
    hwrite(A_FLAGS, 16'h0001);
    expect_reg("R8 clear bit0", A_FLAGS, 16'h0002);
    hwrite(A_FLAGS, 16'h00FF);
    expect_reg("R8 clear all", A_FLAGS, 16'h0000);

    // R3: drain to empty
    hwrite(A_REAR, 16'd1);
    expect_reg("R3 empty", A_CNT, 16'd0);

    // R7: converter error strobe
    @(negedge clk); conv_err = 1;
    @(negedge clk); conv_err = 0;
    expect_reg("R7 hwerr flag", A_FLAGS, 16'h0004);

    // R9: interrupt gating
    check("R9 masked off", {15'd0, irq}, 16'd0);
    hwrite(A_MASK, 16'h0004);
    @(negedge clk);
    check("R9 irq raised", {15'd0, irq}, 16'd1);
    expect_reg("R9 mask readback", A_MASK, 16'h0004);
    hwrite(A_FLAGS, 16'h0004);
    @(negedge clk);
    check("R9 irq drops after clear", {15'd0, irq}, 16'd0);

    // R8: set outranks clear in the same cycle
    @(negedge clk); conv_err = 1; host_wr = 1; host_addr = A_FLAGS; host_wdata = 16'h0004;
    @(negedge clk); conv_err = 0; host_wr = 0;
    @(negedge clk);
    check("R9 irq after set-vs-clear", {15'd0, irq}, 16'd1);
    expect_reg("R8 set beats clear", A_FLAGS, 16'h0004);
    hwrite(A_MASK, 16'h0000);
    @(negedge clk);
    check("R9 zero mask disables", {15'd0, irq}, 16'd0);

    // R6: programmable threshold
    hwrite(A_THR, 16'd2);
    expect_reg("R6 threshold readback", A_THR, 16'd2);
    hwrite(A_FLAGS, 16'h00FF);
    push(16'hC001);
    expect_reg("R6 below threshold", A_FLAGS, 16'h0000);
    push(16'hC002);
    expect_reg("R6 at threshold", A_FLAGS, 16'h0001);
    expect_reg("R10 slot read", 12'h002, 16'hC002);
    expect_reg("R10 unmapped offset", RB + 12'd7, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule